// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the configurable AND-OR core of a small programmable logic device. Twelve dedicated inputs and ten feedback inputs each reach the array in true and inverted form, giving 44 columns. A bank of configuration rows decides which columns each product term observes. The block evaluates every product term combinationally and ORs fixed groups of them into ten sum-of-products results. It also drives a per-output enable term, a shared asynchronous-reset term and a shared synchronous-preset term. The registers, pins and output polarity logic that consume these signals sit outside the block.

Configuration is loaded one row per clock through a row address and a 44-bit data word. A separate read address returns a stored row one cycle later. A lock request hides the stored pattern from readback until the next reset. Reset puts every row into the initial state, in which every connection is made, so every term evaluates LOW.

Top module: `pla_sop_array`

## Requirements
- R1: Signal k drives column 2k with its true value and column 2k+1 with its inverse. Signals 0 to 11 are `ded_in[11:0]` and signals 12 to 21 are `fb_in[9:0]`. A configuration bit of 1 connects that column to the product term.
- R2: A product term whose row has no bit set evaluates HIGH.
- R3: A product term connected to both columns of any one signal evaluates LOW whatever the inputs are.
- R4: Row 0 is the asynchronous-reset term (`ar_term`) and row 131 is the synchronous-preset term (`sp_term`). Rows 1 to 130 hold one block per output, output 0 first. Each block is the output's enable row followed by its sum rows. Outputs 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 sum rows.
- R5: `sop_out[o]` is the OR of output o's sum rows, and `oe_term[o]` is the value of output o's enable row.
- R6: When `cfg_we` is high at a rising edge and `cfg_row` is below 132, that row takes `cfg_wdata`, and the new contents affect the outputs from that edge on. A write to a row address of 132 or above changes no row.
- R7: `cfg_rd_data` shows the row addressed by `cfg_rd_row` at the previous rising edge. For a read address of 132 or above it shows zero.
- R8: A high `lock_req` at a rising edge makes every later readback return zero until reset. Writes still take effect while locked.
- R9: Synchronous active-high `rst` sets every bit of every row to 1, clears the lock and clears `cfg_rd_data`.
- R10: All term outputs follow changes on `ded_in` and `fb_in` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes, readback and lock |
| rst | input | 1 | Synchronous active-high reset |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals from the output cells |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 8 | Row address for writes |
| cfg_wdata | input | 44 | Connection bits for the addressed row |
| cfg_rd_row | input | 8 | Row address for readback |
| lock_req | input | 1 | Request to hide the pattern from readback |
| cfg_rd_data | output | 44 | Registered readback word |
| sop_out | output | 10 | Sum-of-products result per output |
| oe_term | output | 10 | Enable product term per output |
| ar_term | output | 1 | Shared asynchronous-reset product term |
| sp_term | output | 1 | Shared synchronous-preset product term |

## Verification
The assertions assume that `ded_in` and `fb_in` change only between clock edges, so a clock edge with no write leaves the term outputs unchanged unless those inputs move. The bench drives every input on the falling edge and holds it across the rising edge. The no-write check also relies on the reset state having every connection made. The bench therefore holds `rst` for several edges before any write, and every test that needs a clean array begins with a fresh reset.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Sum-term count of output o: rises from the edges towards the middle.
  function automatic int terms_of(input int o, input int n_out,
                                  input int min_t, input int step);
    int d;
    d = (o < (n_out - 1 - o)) ? o : (n_out - 1 - o);
    return min_t + step * d;
  endfunction

  // Row holding the enable term of output o; row 0 is the reset term.
  function automatic int ena_row(input int o, input int n_out,
                                 input int min_t, input int step);
    int r;
    r = 1;
    for (int j = 0; j < o; j++) r += 1 + terms_of(j, n_out, min_t, step);
    return r;
  endfunction

  // Total rows: reset row, per-output blocks, preset row.
  function automatic int rows_total(input int n_out, input int min_t,
                                    input int step);
    return ena_row(n_out, n_out, min_t, step) + 1;
  endfunction

endpackage

// File: rtl/pla_col_drive.sv
module pla_col_drive #(
  parameter int N_SIG = 22,
  localparam int COLS = 2 * N_SIG
) (
  input  logic [N_SIG-1:0] sig,
  output logic [COLS-1:0]  col
);
  for (genvar k = 0; k < N_SIG; k++) begin : g_pair
    assign col[2*k]   = sig[k];
    assign col[2*k+1] = ~sig[k];
  end
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int ROWS = 132,
  parameter int COLS = 44,
  localparam int AW = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_row,
  input  logic [COLS-1:0]      wr_data,
  input  logic [AW-1:0]        rd_row,
  input  logic                 lock_set,
  output logic [COLS-1:0]      rd_data,
  output logic [ROWS*COLS-1:0] plane
);
  logic [COLS-1:0] mem [ROWS];
  logic            locked;
  logic            wr_ok;
  logic            rd_ok;

  assign wr_ok = {1'b0, wr_row} < (AW+1)'(ROWS);
  assign rd_ok = {1'b0, rd_row} < (AW+1)'(ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '1;
    end else if (wr_en && wr_ok) begin
      mem[wr_row] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
    end else if (lock_set) begin
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (locked || !rd_ok) begin
      rd_data <= '0;
    end else begin
      rd_data <= mem[rd_row];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign plane[r*COLS +: COLS] = mem[r];
  end
endmodule

// File: rtl/pla_pterm_plane.sv
module pla_pterm_plane #(
  parameter int ROWS = 132,
  parameter int COLS = 44
) (
  input  logic [COLS-1:0]      cols,
  input  logic [ROWS*COLS-1:0] plane,
  output logic [ROWS-1:0]      pterm
);
  // A column only pulls the term low when it is connected and low.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign pterm[r] = &(~plane[r*COLS +: COLS] | cols);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int ROWS = pla_pkg::rows_total(N_OUT, MIN_TERMS, TERM_STEP)
) (
  input  logic [ROWS-1:0]  pterm,
  output logic [N_OUT-1:0] sop,
  output logic [N_OUT-1:0] oe,
  output logic             ar,
  output logic             sp
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int BASE = pla_pkg::ena_row(o, N_OUT, MIN_TERMS, TERM_STEP);
    localparam int NT   = pla_pkg::terms_of(o, N_OUT, MIN_TERMS, TERM_STEP);
    assign oe[o]  = pterm[BASE];
    assign sop[o] = |pterm[BASE+1 +: NT];
  end
  assign ar = pterm[0];
  assign sp = pterm[ROWS-1];
endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int N_DED     = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_SIG = N_DED + N_OUT,
  localparam int COLS  = 2 * N_SIG,
  localparam int ROWS  = pla_pkg::rows_total(N_OUT, MIN_TERMS, TERM_STEP),
  localparam int AW    = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_OUT-1:0] fb_in,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_row,
  input  logic [COLS-1:0]  cfg_wdata,
  input  logic [AW-1:0]    cfg_rd_row,
  input  logic             lock_req,
  output logic [COLS-1:0]  cfg_rd_data,
  output logic [N_OUT-1:0] sop_out,
  output logic [N_OUT-1:0] oe_term,
  output logic             ar_term,
  output logic             sp_term
);
  logic [COLS-1:0]      cols;
  logic [ROWS*COLS-1:0] plane;
  logic [ROWS-1:0]      pterm;

  pla_col_drive #(.N_SIG(N_SIG)) u_cols (
    .sig ({fb_in, ded_in}),
    .col (cols)
  );

  pla_cfg_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_row   (cfg_row),
    .wr_data  (cfg_wdata),
    .rd_row   (cfg_rd_row),
    .lock_set (lock_req),
    .rd_data  (cfg_rd_data),
    .plane    (plane)
  );

  pla_pterm_plane #(.ROWS(ROWS), .COLS(COLS)) u_and (
    .cols  (cols),
    .plane (plane),
    .pterm (pterm)
  );

  pla_or_plane #(
    .N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)
  ) u_or (
    .pterm (pterm),
    .sop   (sop_out),
    .oe    (oe_term),
    .ar    (ar_term),
    .sp    (sp_term)
  );
endmodule

// File: rtl/pla_sop_array_chk.sv
module pla_sop_array_chk #(
  parameter int N_DED     = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_SIG = N_DED + N_OUT,
  localparam int COLS  = 2 * N_SIG,
  localparam int ROWS  = pla_pkg::rows_total(N_OUT, MIN_TERMS, TERM_STEP),
  localparam int AW    = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_DED-1:0] ded_in,
  input logic [N_OUT-1:0] fb_in,
  input logic             cfg_we,
  input logic [AW-1:0]    cfg_rd_row,
  input logic             lock_req,
  input logic [COLS-1:0]  cfg_rd_data,
  input logic [N_OUT-1:0] sop_out,
  input logic [N_OUT-1:0] oe_term,
  input logic             ar_term,
  input logic             sp_term
);
  logic lock_seen;
  logic wr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_seen <= 1'b0;
      wr_seen   <= 1'b0;
    end else begin
      if (lock_req) lock_seen <= 1'b1;
      if (cfg_we)   wr_seen   <= 1'b1;
    end
  end

  // R8: once a lock request has been taken, readback stays zero.
  p_locked_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    lock_seen |=> (cfg_rd_data == '0));

  // R7: an address past the last row reads back as zero.
  p_range_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cfg_rd_row} >= (AW+1)'(ROWS)) |=> (cfg_rd_data == '0));

  // R3, R9: with no write since reset every term is LOW.
  p_reset_terms_low_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_seen |-> (sop_out == '0 && oe_term == '0 && !ar_term && !sp_term));

  // R6, R10: no write and steady inputs leave the terms unchanged.
  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> (!($stable(ded_in) && $stable(fb_in)) ||
                 $stable({sop_out, oe_term, ar_term, sp_term})));
endmodule

bind pla_sop_array pla_sop_array_chk #(
  .N_DED(N_DED), .N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ded_in      (ded_in),
  .fb_in       (fb_in),
  .cfg_we      (cfg_we),
  .cfg_rd_row  (cfg_rd_row),
  .lock_req    (lock_req),
  .cfg_rd_data (cfg_rd_data),
  .sop_out     (sop_out),
  .oe_term     (oe_term),
  .ar_term     (ar_term),
  .sp_term     (sp_term)
);

// File: tb/pla_sop_array_test.sv
`timescale 1ns/1ps
module pla_sop_array_test;
  localparam int NR = 132;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ded_in = '0;
  logic [9:0]  fb_in = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_row = '0;
  logic [43:0] cfg_wdata = '0;
  logic [7:0]  cfg_rd_row = '0;
  logic        lock_req = 1'b0;
  logic [43:0] cfg_rd_data;
  logic [9:0]  sop_out;
  logic [9:0]  oe_term;
  logic        ar_term;
  logic        sp_term;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [43:0] cfg_m [NR];

  always #2.5 clk = ~clk;

  pla_sop_array uut (
    .clk(clk), .rst(rst), .ded_in(ded_in), .fb_in(fb_in),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_wdata(cfg_wdata),
    .cfg_rd_row(cfg_rd_row), .lock_req(lock_req), .cfg_rd_data(cfg_rd_data),
    .sop_out(sop_out), .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term)
  );

  // Fixed-pattern vectors {ded, fb, sop, oe, ar, sp}; pattern set up in main flow.
  localparam logic [43:0] VEC [8] = '{
    {12'h000, 10'h000, 10'h000, 10'h3FF, 1'b0, 1'b0},
    {12'hFFF, 10'h3FF, 10'h3FF, 10'h000, 1'b1, 1'b0},
    {12'hC00, 10'h000, 10'h000, 10'h3FF, 1'b1, 1'b0},
    {12'h400, 10'h200, 10'h000, 10'h1FF, 1'b0, 1'b1},
    {12'h2AA, 10'h155, 10'h2AA, 10'h2AA, 1'b0, 1'b0},
    {12'h955, 10'h2AA, 10'h155, 10'h155, 1'b0, 1'b0},
    {12'h3C3, 10'h3F0, 10'h3C3, 10'h00F, 1'b0, 1'b1},
    {12'h801, 10'h001, 10'h001, 10'h3FE, 1'b0, 1'b0}
  };

  function automatic int b_terms(int o);
    int lo = (o < 5) ? o : 9 - o;
    return 8 + 2 * lo;
  endfunction

  function automatic int b_ena(int o);
    int r = 1;
    for (int j = 0; j < o; j++) r = r + 1 + b_terms(j);
    return r;
  endfunction

  function automatic logic m_row(int r, logic [21:0] s);
    logic v = 1'b1;
    for (int k = 0; k < 22; k++) begin
      if (cfg_m[r][2*k] && !s[k]) v = 1'b0;
      if (cfg_m[r][2*k+1] && s[k]) v = 1'b0;
    end
    return v;
  endfunction

  function automatic logic [21:0] m_eval(logic [11:0] d, logic [9:0] f);
    logic [21:0] s = {f, d};
    logic [9:0] so = '0;
    logic [9:0] oe = '0;
    for (int o = 0; o < 10; o++) begin
      oe[o] = m_row(b_ena(o), s);
      for (int t = 1; t <= b_terms(o); t++) so[o] = so[o] | m_row(b_ena(o) + t, s);
    end
    return {so, oe, m_row(0, s), m_row(NR - 1, s)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < NR; r++) cfg_m[r] = '1;
    #1;
  endtask

  task automatic wr(input int row, input logic [43:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 8'(row); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (row < NR) cfg_m[row] = data;
    #1;
  endtask

  task automatic rd(input int row, output logic [43:0] data);
    @(negedge clk);
    cfg_rd_row = 8'(row);
    @(negedge clk);
    data = cfg_rd_data;
  endtask

  task automatic drive(input logic [11:0] d, input logic [9:0] f);
    @(negedge clk);
    ded_in = d; fb_in = f;
    #1;
  endtask

  function automatic logic [21:0] outs();
    return {sop_out, oe_term, ar_term, sp_term};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [43:0] rdv;
    do_reset();

    // Reset state: every connection made, all terms LOW.
    chk("R9 reset terms low", 64'(outs()), 64'(0));
    rd(5, rdv);
    chk("R9 reset row all ones", 64'(rdv), 64'(44'hFFF_FFFF_FFFF));
    rd(200, rdv);
    chk("R7 out of range read zero", 64'(rdv), 64'(0));

    // Out-of-range write: row 140 must not alias onto row 12.
    wr(140, '0);
    chk("R6 ignored write outputs", 64'(outs()), 64'(0));
    rd(12, rdv);
    chk("R6 ignored write row 12", 64'(rdv), 64'(44'hFFF_FFFF_FFFF));

    // Empty rows evaluate HIGH; row placement of reset, preset, last sum row.
    wr(0, '0);
    chk("R2 R4 empty reset row", 64'(ar_term), 64'(1));
    wr(NR - 1, '0);
    chk("R4 preset row", 64'(sp_term), 64'(1));
    wr(b_ena(9) + b_terms(9), '0);
    chk("R4 R5 last sum row of output 9", 64'(sop_out), 64'(10'h200));
    wr(b_ena(4), '0);
    chk("R5 enable row of output 4", 64'(oe_term), 64'(10'h010));
    rd(b_ena(4), rdv);
    chk("R7 readback after write", 64'(rdv), 64'(0));

    // Both polarities of one signal: LOW for either value.
    do_reset();
    wr(b_ena(0) + 1, 44'h0C0);
    drive(12'h008, '0);
    chk("R3 both polarities, input high", 64'(sop_out[0]), 64'(0));
    drive(12'h000, '0);
    chk("R3 both polarities, input low", 64'(sop_out[0]), 64'(0));
    wr(b_ena(0) + 1, 44'h040);
    chk("R1 true column of ded 3, low", 64'(sop_out[0]), 64'(0));
    drive(12'h008, '0);
    chk("R10 R1 follows input without edge", 64'(sop_out[0]), 64'(1));

    // Fixed pattern then table walk.
    do_reset();
    for (int o = 0; o < 10; o++) begin
      wr(b_ena(o) + 1, 44'(1) << (2 * o));
      wr(b_ena(o), 44'(1) << (2 * (12 + o) + 1));
    end
    wr(0, (44'(1) << 20) | (44'(1) << 22));
    wr(NR - 1, (44'(1) << 23) | (44'(1) << 42));
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][43:32], VEC[i][31:22]);
      chk($sformatf("R1 R5 R10 table vector %0d", i), 64'(outs()), 64'(VEC[i][21:0]));
    end

    // Lock behaviour.
    rd(0, rdv);
    chk("R7 readback before lock", 64'(rdv), 64'(44'h500000));
    @(negedge clk); lock_req = 1'b1;
    @(negedge clk); lock_req = 1'b0;
    rd(0, rdv);
    chk("R8 locked read zero", 64'(rdv), 64'(0));
    drive(12'h000, '0);
    wr(0, '0);
    chk("R8 write while locked", 64'(ar_term), 64'(1));
    rd(0, rdv);
    chk("R8 still locked", 64'(rdv), 64'(0));
    do_reset();
    rd(0, rdv);
    chk("R9 reset clears lock and rows", 64'(rdv), 64'(44'hFFF_FFFF_FFFF));
    chk("R9 reset term state", 64'(ar_term), 64'(0));

    // Random patterns against the bench model.
    for (int it = 0; it < 40; it++) begin
      do_reset();
      for (int n = 0; n < 30; n++) begin
        logic [43:0] dat = '0;
        for (int k = 0; k < 22; k++) begin
          int c = $urandom % 10;
          if (c == 0) dat[2*k] = 1'b1;
          else if (c == 1) dat[2*k+1] = 1'b1;
          else if (c == 2 && ($urandom % 8) == 0) dat[2*k +: 2] = 2'b11;
        end
        wr($urandom % NR, dat);
      end
      for (int v = 0; v < 8; v++) begin
        logic [11:0] d = 12'($urandom);
        logic [9:0]  f = 10'($urandom);
        drive(d, f);
        chk("R4 R5 random pattern", 64'(outs()), 64'(m_eval(d, f)));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule